// File: doc/BRIEF.md
# Double-Buffered Crosspoint Connection Array

This block holds the connection state of a digital crosspoint with `N_IN` inputs and `N_OUT` outputs. Each crosspoint carries two bits: a staged bit that configuration commands edit, and a live bit that drives the data path. A configuration front end delivers decoded commands, each an opcode with an input index and an output index. These commands only edit the staged plane. An active-low commit input copies the whole staged plane into the live plane on a clock edge, so the entire matrix changes at once. If the commit input is held low, every command takes effect on the edge that accepts it.

Each output is driven by at most one input, and one input may feed any number of outputs. The block presents a valid bit and an input index for each output, which the data path uses as a mux select. It also returns the staged and live state of one addressed crosspoint for readback. A broadcast overlay routes one chosen input to every output without touching either plane. The next commit removes the overlay, so the earlier connection state becomes visible again.

Top module: `xbar_cfg_array`

## Requirements
- R1: After asynchronous reset (`rst_ni` low), both planes hold no connections, broadcast is off, and every `route_vld_o` bit and every `route_sel_o` field is 0.
- R2: While `update_ni` is high on a clock edge, the live plane does not change on that edge, so commands other than broadcast leave `route_vld_o`/`route_sel_o` unchanged.
- R3: On every clock edge where `update_ni` is low, the live plane takes the staged plane, including the change made by a command accepted on that same edge.
- R4: Connect (`cmd_op_i` = 1) stages link (i, o) and clears every other input on output o. Links from input i to other outputs stay. At most one input is ever staged per output.
- R5: Exclusive connect (`cmd_op_i` = 2) stages link (i, o) and clears every other crosspoint in input row i and output column o.
- R6: Pair disconnect (`cmd_op_i` = 3) clears only crosspoint (i, o). Every other link is unchanged.
- R7: Input disconnect (`cmd_op_i` = 4) clears every crosspoint in row i. `cmd_out_i` is ignored.
- R8: Array clear (`cmd_op_i` = 5) empties the staged plane only. Live routing changes at the next commit.
- R9: Broadcast (`cmd_op_i` = 6) accepted while `update_ni` is high makes every output valid with input i selected, and it leaves both planes untouched. The first edge with `update_ni` low ends broadcast, and routing then follows the live plane.
- R10: A broadcast command on an edge where `update_ni` is low does not start broadcast.
- R11: A command whose input index is not below `N_IN`, or whose output index (for opcodes 1, 2, 3) is not below `N_OUT`, changes nothing. Opcode 0 and opcode 7 change nothing.
- R12: `rd_pend_o` is the staged bit and `rd_live_o` is the routed state (the broadcast overlay included) of crosspoint (`rd_in_i`, `rd_out_i`). Both are combinational and both are 0 for an index that is out of range. The routing field of output o is `route_sel_o[o*IW +: IW]`, where IW = max(1, clog2(N_IN)). A field is 0 when its valid bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| update_ni | input | 1 | Active-low commit of the staged plane into the live plane |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Opcode: 0 nop, 1 connect, 2 exclusive connect, 3 pair disconnect, 4 input disconnect, 5 clear, 6 broadcast |
| cmd_in_i | input | IW | Input index of the command |
| cmd_out_i | input | OW | Output index of the command |
| rd_in_i | input | IW | Readback input index |
| rd_out_i | input | OW | Readback output index |
| rd_pend_o | output | 1 | Staged bit of the addressed crosspoint |
| rd_live_o | output | 1 | Routed state of the addressed crosspoint |
| route_vld_o | output | N_OUT | Per-output driven flag |
| route_sel_o | output | N_OUT*IW | Per-output selected input index |

## Verification
The bench builds the block with `N_IN` = 5 and `N_OUT` = 3. A 3-bit input index then has three codes that are out of range, and a 2-bit output index has one, which makes the rejection of bad indices reachable at the ports. With 15 crosspoints, the bench can sweep every pair for each command type and read back the whole index space after every command. The commit input is tested both held low and pulsed, and broadcast is entered from every input.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_CONNECT = 3'd1,
    OP_CONX    = 3'd2,
    OP_DISPAIR = 3'd3,
    OP_DISIN   = 3'd4,
    OP_CLEAR   = 3'd5,
    OP_BCAST   = 3'd6,
    OP_RSVD    = 3'd7
  } xbar_op_e;
endpackage

// File: rtl/xbar_plane_next.sv
module xbar_plane_next #(
  parameter int N_IN  = 5,
  parameter int N_OUT = 3,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic [N_OUT-1:0][N_IN-1:0] cur_i,
  input  logic                       cmd_valid_i,
  input  logic [2:0]                 cmd_op_i,
  input  logic [IW-1:0]              cmd_in_i,
  input  logic [OW-1:0]              cmd_out_i,
  output logic [N_OUT-1:0][N_IN-1:0] nxt_o
);
  import xbar_pkg::*;

  xbar_op_e op;
  logic in_ok, out_ok;

  always_comb begin
    op     = xbar_op_e'(cmd_op_i);
    in_ok  = 32'(cmd_in_i) < N_IN;
    out_ok = 32'(cmd_out_i) < N_OUT;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    for (genvar i = 0; i < N_IN; i++) begin : g_row
      logic hit_i, hit_o;
      always_comb begin
        hit_i = in_ok && (32'(cmd_in_i) == i);
        hit_o = out_ok && (32'(cmd_out_i) == o);
        nxt_o[o][i] = cur_i[o][i];
        if (cmd_valid_i) begin
          unique case (op)
            OP_CONNECT: if (hit_o && in_ok)           nxt_o[o][i] = hit_i;
            OP_CONX:    if ((hit_o && in_ok) || (hit_i && out_ok))
                                                      nxt_o[o][i] = hit_i && hit_o;
            OP_DISPAIR: if (hit_i && hit_o)           nxt_o[o][i] = 1'b0;
            OP_DISIN:   if (hit_i)                    nxt_o[o][i] = 1'b0;
            OP_CLEAR:                                 nxt_o[o][i] = 1'b0;
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/xbar_col_encode.sv
module xbar_col_encode #(
  parameter int N_IN = 5,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1
) (
  input  logic [N_IN-1:0] col_i,
  output logic            vld_o,
  output logic [IW-1:0]   sel_o
);
  // lowest set index wins; column is one-hot or empty by construction
  always_comb begin
    vld_o = 1'b0;
    sel_o = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (col_i[i]) begin
        vld_o = 1'b1;
        sel_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/xbar_cfg_array.sv
module xbar_cfg_array #(
  parameter int N_IN  = 5,
  parameter int N_OUT = 3,
  localparam int IW = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               update_ni,
  input  logic               cmd_valid_i,
  input  logic [2:0]         cmd_op_i,
  input  logic [IW-1:0]      cmd_in_i,
  input  logic [OW-1:0]      cmd_out_i,
  input  logic [IW-1:0]      rd_in_i,
  input  logic [OW-1:0]      rd_out_i,
  output logic               rd_pend_o,
  output logic               rd_live_o,
  output logic [N_OUT-1:0]   route_vld_o,
  output logic [N_OUT*IW-1:0] route_sel_o
);
  import xbar_pkg::*;

  logic [N_OUT-1:0][N_IN-1:0] load_q, load_d, act_q;
  logic                       bcast_q;
  logic [IW-1:0]              bcast_idx_q;
  logic                       bcast_set;
  logic [N_OUT-1:0]           col_vld;
  logic [N_OUT-1:0][IW-1:0]   col_sel;

  xbar_plane_next #(.N_IN(N_IN), .N_OUT(N_OUT)) i_next (
    .cur_i       (load_q),
    .cmd_valid_i (cmd_valid_i),
    .cmd_op_i    (cmd_op_i),
    .cmd_in_i    (cmd_in_i),
    .cmd_out_i   (cmd_out_i),
    .nxt_o       (load_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= '0;
      act_q  <= '0;
    end else begin
      load_q <= load_d;
      if (!update_ni) act_q <= load_d;
    end
  end

  assign bcast_set = cmd_valid_i && (xbar_op_e'(cmd_op_i) == OP_BCAST)
                     && (32'(cmd_in_i) < N_IN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcast_q     <= 1'b0;
      bcast_idx_q <= '0;
    end else if (!update_ni) begin
      bcast_q     <= 1'b0;
    end else if (bcast_set) begin
      bcast_q     <= 1'b1;
      bcast_idx_q <= cmd_in_i;
    end
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    xbar_col_encode #(.N_IN(N_IN)) i_enc (
      .col_i (act_q[o]),
      .vld_o (col_vld[o]),
      .sel_o (col_sel[o])
    );
    always_comb begin
      route_vld_o[o]          = bcast_q ? 1'b1 : col_vld[o];
      route_sel_o[o*IW +: IW] = bcast_q ? bcast_idx_q : col_sel[o];
    end
  end

  always_comb begin
    rd_pend_o = 1'b0;
    rd_live_o = 1'b0;
    if (32'(rd_in_i) < N_IN && 32'(rd_out_i) < N_OUT) begin
      rd_pend_o = load_q[rd_out_i][rd_in_i];
      rd_live_o = bcast_q ? (rd_in_i == bcast_idx_q) : act_q[rd_out_i][rd_in_i];
    end
  end
endmodule

// File: rtl/xbar_cfg_array_chk.sv
module xbar_cfg_array_chk #(
  parameter int N_IN  = 5,
  parameter int N_OUT = 3
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       update_ni,
  input logic                       cmd_valid_i,
  input logic [2:0]                 cmd_op_i,
  input logic [N_OUT-1:0][N_IN-1:0] load_q,
  input logic [N_OUT-1:0][N_IN-1:0] act_q,
  input logic                       bcast_q,
  input logic [N_OUT-1:0]           route_vld_o
);
  p_live_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_ni |=> $stable(act_q));

  p_commit_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_ni |=> (act_q == load_q));

  p_clear_stage_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_op_i == 3'd5) |=> (load_q == '0));

  p_bcast_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_ni |=> !bcast_q);

  p_bcast_all_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_q |-> (&route_vld_o));

  for (genvar o = 0; o < N_OUT; o++) begin : g_col
    p_col_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(load_q[o]) && $onehot0(act_q[o]));
  end
endmodule

bind xbar_cfg_array xbar_cfg_array_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .update_ni   (update_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_op_i    (cmd_op_i),
  .load_q      (load_q),
  .act_q       (act_q),
  .bcast_q     (bcast_q),
  .route_vld_o (route_vld_o)
);

// File: tb/test_xbar_cfg_array.sv
`timescale 1ns/10ps
module test_xbar_cfg_array;
  localparam int NI = 5;
  localparam int NO = 3;
  localparam int IW = 3;
  localparam int OW = 2;
  localparam real CLK_PERIOD = 20.0;

  logic clk = 0, rst_n = 0, update_n = 1, cmd_valid = 0;
  logic [2:0] cmd_op = 0;
  logic [IW-1:0] cmd_in = 0, rd_in = 0;
  logic [OW-1:0] cmd_out = 0, rd_out = 0;
  logic rd_pend, rd_live;
  logic [NO-1:0] route_vld;
  logic [NO*IW-1:0] route_sel;

  int checks = 0, fails = 0;
  bit ref_load [NO][NI];
  bit ref_act  [NO][NI];
  bit ref_bc = 0;
  int ref_bci = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xbar_cfg_array #(.N_IN(NI), .N_OUT(NO)) i_xbar_cfg_array (
    .clk_i(clk), .rst_ni(rst_n), .update_ni(update_n),
    .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_in_i(cmd_in), .cmd_out_i(cmd_out),
    .rd_in_i(rd_in), .rd_out_i(rd_out), .rd_pend_o(rd_pend), .rd_live_o(rd_live),
    .route_vld_o(route_vld), .route_sel_o(route_sel)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compares routing and sweeps readback over the full index space (R12)
  task automatic check_all(input string req);
    for (int o = 0; o < NO; o++) begin
      int ev = ref_bc ? 1 : 0;
      int es = ref_bc ? ref_bci : 0;
      if (!ref_bc)
        for (int i = NI - 1; i >= 0; i--)
          if (ref_act[o][i]) begin ev = 1; es = i; end
      chk(req, $sformatf("route_vld[%0d]", o), int'(route_vld[o]), ev);
      chk(req, $sformatf("route_sel[%0d]", o), int'(route_sel[o*IW +: IW]), es);
    end
    for (int ri = 0; ri < (1 << IW); ri++)
      for (int ro = 0; ro < (1 << OW); ro++) begin
        int ep = 0, el = 0;
        rd_in = IW'(ri); rd_out = OW'(ro);
        #0.25;
        if (ri < NI && ro < NO) begin
          ep = ref_load[ro][ri];
          el = ref_bc ? int'(ri == ref_bci) : int'(ref_act[ro][ri]);
        end
        chk({"R12/", req}, $sformatf("rd_pend(%0d,%0d)", ri, ro), int'(rd_pend), ep);
        chk({"R12/", req}, $sformatf("rd_live(%0d,%0d)", ri, ro), int'(rd_live), el);
      end
  endtask

  task automatic model(input int op, input int ci, input int co, input bit up);
    bit iok = ci < NI;
    bit ook = co < NO;
    for (int o = 0; o < NO; o++)
      for (int i = 0; i < NI; i++)
        case (op)
          1: if (iok && ook && o == co) ref_load[o][i] = (i == ci);
          2: if (iok && ook && (o == co || i == ci)) ref_load[o][i] = (o == co && i == ci);
          3: if (iok && ook && o == co && i == ci) ref_load[o][i] = 0;
          4: if (iok && i == ci) ref_load[o][i] = 0;
          5: ref_load[o][i] = 0;
          default: ;
        endcase
    if (op == 6 && up && iok) begin ref_bc = 1; ref_bci = ci; end
    if (!up) begin
      ref_act = ref_load;
      ref_bc = 0;
    end
  endtask

  task automatic cmd(input int op, input int ci, input int co, input bit up, input string req);
    cmd_valid = 1; cmd_op = 3'(op); cmd_in = IW'(ci); cmd_out = OW'(co); update_n = up;
    @(posedge clk);
    model(op, ci, co, up);
    @(negedge clk);
    cmd_valid = 0; cmd_op = 0; update_n = 1;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_n = 1;
    @(negedge clk);

    // R2: staged edits with commit high never reach routing; R4 visible on rd_pend
    for (int i = 0; i < NI; i++)
      for (int o = 0; o < NO; o++) cmd(1, i, o, 1, "R2");
    cmd(0, 0, 0, 0, "R3");

    // R4 fan-out kept, column replaced
    cmd(1, 0, 0, 0, "R4");
    cmd(1, 0, 1, 0, "R4");
    cmd(1, 0, 2, 0, "R4");
    cmd(1, 3, 1, 0, "R4");
    cmd(1, 2, 2, 1, "R4");
    cmd(0, 0, 0, 0, "R3");

    // R5 exclusive connect sweep
    for (int i = 0; i < NI; i++)
      for (int o = 0; o < NO; o++) cmd(2, i, o, (i + o) % 2, "R5");
    for (int o = 0; o < NO; o++) cmd(1, 1, o, 0, "R4");
    cmd(2, 4, 1, 0, "R5");
    cmd(2, 1, 0, 0, "R5");

    // R6 pair disconnect
    cmd(1, 1, 1, 0, "R4");
    cmd(1, 1, 2, 0, "R4");
    cmd(3, 1, 1, 0, "R6");
    cmd(3, 0, 0, 0, "R6");
    cmd(3, 1, 2, 1, "R6");
    cmd(0, 0, 0, 0, "R3");

    // R7 row clear, out index ignored
    for (int o = 0; o < NO; o++) cmd(1, 2, o, 0, "R4");
    cmd(4, 2, 3, 0, "R7");
    cmd(1, 3, 0, 0, "R4");
    cmd(1, 4, 1, 0, "R4");
    cmd(4, 3, 0, 0, "R7");

    // R8 clear staged only, then commit
    cmd(1, 0, 0, 0, "R4");
    cmd(1, 2, 2, 0, "R4");
    cmd(5, 0, 0, 1, "R8");
    cmd(0, 0, 0, 1, "R8");
    cmd(0, 0, 0, 0, "R8");

    // R9 broadcast from every input, then exit restores live plane
    cmd(1, 1, 0, 0, "R4");
    cmd(1, 3, 2, 0, "R4");
    for (int b = 0; b < NI; b++) cmd(6, b, 0, 1, "R9");
    cmd(1, 2, 1, 1, "R9");
    cmd(0, 0, 0, 0, "R9");
    cmd(6, 2, 0, 1, "R9");
    cmd(5, 0, 0, 0, "R9");

    // R10 broadcast with commit low
    cmd(1, 4, 0, 0, "R4");
    cmd(6, 3, 0, 0, "R10");

    // R11 out-of-range indices and reserved opcode
    cmd(1, 5, 0, 0, "R11");
    cmd(1, 7, 1, 0, "R11");
    cmd(1, 0, 3, 0, "R11");
    cmd(2, 6, 2, 0, "R11");
    cmd(2, 0, 3, 0, "R11");
    cmd(3, 4, 3, 0, "R11");
    cmd(4, 5, 0, 0, "R11");
    cmd(6, 7, 0, 1, "R11");
    cmd(7, 4, 0, 0, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule